// File: doc/BRIEF.md
# Windowed Outbound Address Translator

This block sits on the slave side of an AXI path heading toward a PCIe link and rewrites outgoing 64-bit addresses. It holds eight programmable entries. Each entry describes a source window whose size is a power of two. The entry gives the window's base in the AXI address space, a translated base, and a 32-bit parameter word that tags the resulting request as a memory or configuration access and records its direction.

Software loads the entries through a simple 32-bit register port that has separate write and read strobes. The datapath then presents an address with a valid strobe. One clock later the block returns the following:

- the translated address,
- the parameter word of the winning entry,
- the index of that entry,
- a hit flag.

When no entry matches, the address comes back unchanged with the hit flag low.

Top module: `xlat_window_table`

## Requirements
- R1: After reset every entry is disabled, every table register reads zero, and `res_valid` and `res_hit` are low.
- R2: Entry k's registers sit at byte address 0x800 + 0x20·k. Within an entry the words are placed as follows: source-low at +0x0, source-high at +0x4, translated-low at +0x8, translated-high at +0xC and parameter at +0x10. A read strobe returns the addressed word on `cfg_rd_data` one cycle later.
- R3: In source-low, the fields are laid out as follows: bit 0 is the enable, bits 6:1 hold the size code W, bits 11:7 always read zero, and bits 31:12 hold source base bits 31:12. In translated-low, bits 11:0 always read zero and act as zero.
- R4: A window spans 2^(W+1) bytes. An address hits an enabled entry when every address bit at position W+1 and above equals the source base, where the source base is {source-high, source-low[31:12], 12'h000}.
- R5: On a hit, `res_addr` carries the translated base {translated-high, translated-low[31:12], 12'h000} in bits W+1 and above, and the input address in bits W and below.
- R6: A disabled entry never hits, even when its base matches.
- R7: When several entries hit, the lowest-numbered one wins, and its number appears on `res_index`.
- R8: On a miss, `res_hit` is 0, `res_addr` equals the input address, and `res_param` and `res_index` are 0.
- R9: On a hit, `res_param` returns the winning entry's parameter word exactly as written. Its bit 22 is the direction flag, and its low type field is 0 for a memory request and 1 for a configuration request.
- R10: Each cycle with `lk_valid` high yields exactly one result, with `res_valid` high in the following cycle. Back-to-back lookups give back-to-back results.
- R11: When a register write and a lookup occur in the same cycle, the lookup sees the table as it was before the write. The write affects lookups from the next cycle on.
- R12: Writes to offsets +0x14 to +0x1C of an entry, or to addresses outside 0x800–0x8FF, change nothing, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 12 | Register write byte address |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_rd_addr | input | 12 | Register read byte address |
| cfg_rd_data | output | 32 | Registered read data |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 64 | Address to translate |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | An enabled entry matched |
| res_addr | output | 64 | Translated or passed-through address |
| res_param | output | 32 | Parameter word of the winning entry |
| res_index | output | 3 | Number of the winning entry |

## Verification
A register write and a lookup can fall in the same clock. The bench provokes this by strobing a write that disables entry 5 in the very cycle that a lookup targets entry 5's window. The scoreboard expects that lookup to hit with entry 5's old translation, and expects the lookup issued on the next cycle to miss. The same bench model also covers several other cases:

- overlapping windows, where the lowest entry must win,
- window edges at the smallest and largest size codes,
- pass-through on a miss.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int unsigned XA_W   = 64;
  localparam int unsigned CW_W   = 32;
  localparam int unsigned PAGE_W = 12;
  localparam int unsigned WEXP_W = 6;

  // word index of each register inside one entry
  localparam int unsigned WD_SRC_LO = 0;
  localparam int unsigned WD_SRC_HI = 1;
  localparam int unsigned WD_TRL_LO = 2;
  localparam int unsigned WD_TRL_HI = 3;
  localparam int unsigned WD_PARAM  = 4;

  typedef struct packed {
    logic                       en;
    logic [WEXP_W-1:0]          wexp;
    logic [CW_W-PAGE_W-1:0]     src_lo;
    logic [CW_W-1:0]            src_hi;
    logic [CW_W-PAGE_W-1:0]     trl_lo;
    logic [CW_W-1:0]            trl_hi;
    logic [CW_W-1:0]            param;
  } xlat_entry_t;

  // mask of the address bits that lie inside a window of code w
  function automatic logic [XA_W-1:0] win_mask(input logic [WEXP_W-1:0] w);
    return {XA_W{1'b1}} >> (WEXP_W'(XA_W - 1) - w);
  endfunction

  function automatic logic [CW_W-1:0] src_lo_word(input xlat_entry_t e);
    return {e.src_lo, {(PAGE_W-WEXP_W-1){1'b0}}, e.wexp, e.en};
  endfunction

endpackage

// File: rtl/xlat_entry_regs.sv
module xlat_entry_regs
  import xlat_pkg::*;
#(
  parameter int unsigned NUM_ENT    = 8,
  parameter int unsigned REG_AW     = 12,
  parameter int unsigned TABLE_BASE = 'h800,
  parameter int unsigned ENT_STRIDE = 'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [CW_W-1:0]   wr_data,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [CW_W-1:0]   rd_data,
  output xlat_entry_t       ent_o [NUM_ENT]
);

  localparam int unsigned IDX_W     = $clog2(NUM_ENT);
  localparam int unsigned STRIDE_SH = $clog2(ENT_STRIDE);
  localparam int unsigned WSEL_W    = STRIDE_SH - 2;
  localparam int unsigned TOP_SH    = STRIDE_SH + IDX_W;
  localparam logic [REG_AW-1:0] BASE_V = REG_AW'(TABLE_BASE);

  logic [REG_AW-1:0] wr_rel, rd_rel;
  logic              wr_in, rd_in;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [WSEL_W-1:0] wr_sel, rd_sel;

  assign wr_rel = wr_addr - BASE_V;
  assign rd_rel = rd_addr - BASE_V;
  assign wr_in  = (wr_addr >= BASE_V) && ((wr_rel >> TOP_SH) == '0) && (wr_rel[1:0] == 2'b00);
  assign rd_in  = (rd_addr >= BASE_V) && ((rd_rel >> TOP_SH) == '0) && (rd_rel[1:0] == 2'b00);
  assign wr_idx = wr_rel[STRIDE_SH +: IDX_W];
  assign rd_idx = rd_rel[STRIDE_SH +: IDX_W];
  assign wr_sel = wr_rel[STRIDE_SH-1:2];
  assign rd_sel = rd_rel[STRIDE_SH-1:2];

  for (genvar k = 0; k < NUM_ENT; k++) begin : g_ent
    logic sel_k;
    assign sel_k = wr_en && wr_in && (wr_idx == IDX_W'(k));
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_o[k] <= '0;
      end else if (sel_k) begin
        if (wr_sel == WSEL_W'(WD_SRC_LO)) begin
          ent_o[k].en     <= wr_data[0];
          ent_o[k].wexp   <= wr_data[WEXP_W:1];
          ent_o[k].src_lo <= wr_data[CW_W-1:PAGE_W];
        end
        if (wr_sel == WSEL_W'(WD_SRC_HI)) ent_o[k].src_hi <= wr_data;
        if (wr_sel == WSEL_W'(WD_TRL_LO)) ent_o[k].trl_lo <= wr_data[CW_W-1:PAGE_W];
        if (wr_sel == WSEL_W'(WD_TRL_HI)) ent_o[k].trl_hi <= wr_data;
        if (wr_sel == WSEL_W'(WD_PARAM))  ent_o[k].param  <= wr_data;
      end
    end
  end

  logic [CW_W-1:0] rd_mux;
  xlat_entry_t     rd_ent;

  assign rd_ent = ent_o[rd_idx];

  always_comb begin
    rd_mux = '0;
    if (rd_in) begin
      if (rd_sel == WSEL_W'(WD_SRC_LO)) rd_mux = src_lo_word(rd_ent);
      if (rd_sel == WSEL_W'(WD_SRC_HI)) rd_mux = rd_ent.src_hi;
      if (rd_sel == WSEL_W'(WD_TRL_LO)) rd_mux = {rd_ent.trl_lo, {PAGE_W{1'b0}}};
      if (rd_sel == WSEL_W'(WD_TRL_HI)) rd_mux = rd_ent.trl_hi;
      if (rd_sel == WSEL_W'(WD_PARAM))  rd_mux = rd_ent.param;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

endmodule

// File: rtl/xlat_lookup.sv
module xlat_lookup
  import xlat_pkg::*;
#(
  parameter int unsigned NUM_ENT = 8
) (
  input  xlat_entry_t                ent [NUM_ENT],
  input  logic [XA_W-1:0]            addr,
  output logic                       any_hit,
  output logic [$clog2(NUM_ENT)-1:0] sel_idx,
  output logic [XA_W-1:0]            sel_addr,
  output logic [CW_W-1:0]            sel_param
);

  localparam int unsigned IDX_W = $clog2(NUM_ENT);

  logic [NUM_ENT-1:0] hit_vec;
  logic [XA_W-1:0]    xaddr [NUM_ENT];

  for (genvar k = 0; k < NUM_ENT; k++) begin : g_match
    logic [XA_W-1:0] mask_k, sbase_k, tbase_k;
    assign mask_k     = win_mask(ent[k].wexp);
    assign sbase_k    = {ent[k].src_hi, ent[k].src_lo, {PAGE_W{1'b0}}};
    assign tbase_k    = {ent[k].trl_hi, ent[k].trl_lo, {PAGE_W{1'b0}}};
    assign hit_vec[k] = ent[k].en && (((addr ^ sbase_k) & ~mask_k) == '0);
    assign xaddr[k]   = (tbase_k & ~mask_k) | (addr & mask_k);
  end

  // lowest-numbered hitting entry takes priority
  always_comb begin
    sel_idx = '0;
    for (int k = NUM_ENT - 1; k >= 0; k--) begin
      if (hit_vec[k]) sel_idx = IDX_W'(k);
    end
  end

  assign any_hit   = |hit_vec;
  assign sel_addr  = xaddr[sel_idx];
  assign sel_param = ent[sel_idx].param;

endmodule

// File: rtl/xlat_window_table.sv
module xlat_window_table
  import xlat_pkg::*;
#(
  parameter int unsigned NUM_ENT    = 8,
  parameter int unsigned REG_AW     = 12,
  parameter int unsigned TABLE_BASE = 'h800,
  parameter int unsigned ENT_STRIDE = 'h20
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_wr_en,
  input  logic [REG_AW-1:0]          cfg_wr_addr,
  input  logic [31:0]                cfg_wr_data,
  input  logic                       cfg_rd_en,
  input  logic [REG_AW-1:0]          cfg_rd_addr,
  output logic [31:0]                cfg_rd_data,
  input  logic                       lk_valid,
  input  logic [63:0]                lk_addr,
  output logic                       res_valid,
  output logic                       res_hit,
  output logic [63:0]                res_addr,
  output logic [31:0]                res_param,
  output logic [$clog2(NUM_ENT)-1:0] res_index
);

  localparam int unsigned IDX_W = $clog2(NUM_ENT);

  xlat_entry_t       ent [NUM_ENT];
  logic              any_hit;
  logic [IDX_W-1:0]  sel_idx;
  logic [XA_W-1:0]   sel_addr;
  logic [CW_W-1:0]   sel_param;

  xlat_entry_regs #(
    .NUM_ENT   (NUM_ENT),
    .REG_AW    (REG_AW),
    .TABLE_BASE(TABLE_BASE),
    .ENT_STRIDE(ENT_STRIDE)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_wr_en),
    .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data),
    .rd_en  (cfg_rd_en),
    .rd_addr(cfg_rd_addr),
    .rd_data(cfg_rd_data),
    .ent_o  (ent)
  );

  xlat_lookup #(
    .NUM_ENT(NUM_ENT)
  ) u_lookup (
    .ent      (ent),
    .addr     (lk_addr),
    .any_hit  (any_hit),
    .sel_idx  (sel_idx),
    .sel_addr (sel_addr),
    .sel_param(sel_param)
  );

  // registered result stage: table state before this edge is used
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_addr  <= '0;
      res_param <= '0;
      res_index <= '0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_hit   <= any_hit;
        res_addr  <= any_hit ? sel_addr  : lk_addr;
        res_param <= any_hit ? sel_param : '0;
        res_index <= any_hit ? sel_idx   : '0;
      end
    end
  end

endmodule

// File: rtl/xlat_window_table_chk.sv
module xlat_window_table_chk #(
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic [63:0]      lk_addr,
  input logic             res_valid,
  input logic             res_hit,
  input logic [63:0]      res_addr,
  input logic [31:0]      res_param,
  input logic [IDX_W-1:0] res_index
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (!res_valid && !res_hit)); // R1

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid); // R10

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid); // R10

  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (res_hit || (res_addr == $past(lk_addr)))); // R8

  AST_MISS_ZERO_TAGS: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_param == '0 && res_index == '0)); // R8

  AST_PAGE_BITS_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> ((res_addr[11:0] & ~$past(lk_addr[11:0])) == 12'h000)); // R5

endmodule

bind xlat_window_table xlat_window_table_chk #(.IDX_W($clog2(NUM_ENT))) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lk_valid (lk_valid),
  .lk_addr  (lk_addr),
  .res_valid(res_valid),
  .res_hit  (res_hit),
  .res_addr (res_addr),
  .res_param(res_param),
  .res_index(res_index)
);

// File: tb/xlat_window_table_tb.sv
module xlat_window_table_tb;

  typedef struct packed {
    logic        hit;
    logic [63:0] addr;
    logic [31:0] param;
    logic [2:0]  idx;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [11:0] cfg_wr_addr = '0;
  logic [31:0] cfg_wr_data = '0;
  logic        cfg_rd_en = 1'b0;
  logic [11:0] cfg_rd_addr = '0;
  logic [31:0] cfg_rd_data;
  logic        lk_valid = 1'b0;
  logic [63:0] lk_addr = '0;
  logic        res_valid, res_hit;
  logic [63:0] res_addr;
  logic [31:0] res_param;
  logic [2:0]  res_index;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t  sb_q[$];
  string tag_q[$];

  logic [31:0] m_slo [8];
  logic [31:0] m_shi [8];
  logic [31:0] m_tlo [8];
  logic [31:0] m_thi [8];
  logic [31:0] m_prm [8];

  always #4 clk = ~clk;

  xlat_window_table u_dut (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_en(cfg_rd_en), .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_addr(res_addr),
    .res_param(res_param), .res_index(res_index)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // model of the register file per R2, R3, R12
  function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
    int k;
    int w;
    if (a < 12'h800 || a > 12'h8FF || a[1:0] != 2'b00) return;
    k = int'(a[7:5]);
    w = int'(a[4:2]);
    case (w)
      0: m_slo[k] = d & 32'hFFFF_F07F;
      1: m_shi[k] = d;
      2: m_tlo[k] = d & 32'hFFFF_F000;
      3: m_thi[k] = d;
      4: m_prm[k] = d;
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int k;
    if (a < 12'h800 || a > 12'h8FF || a[1:0] != 2'b00) return 32'h0;
    k = int'(a[7:5]);
    case (int'(a[4:2]))
      0: return m_slo[k];
      1: return m_shi[k];
      2: return m_tlo[k];
      3: return m_thi[k];
      4: return m_prm[k];
      default: return 32'h0;
    endcase
  endfunction

  // expected result per R4..R9
  function automatic exp_t model_lookup(input logic [63:0] a);
    exp_t e;
    e = '{hit: 1'b0, addr: a, param: 32'h0, idx: 3'd0};
    for (int k = 7; k >= 0; k--) begin
      logic [63:0] msk, sb, tb;
      msk = 64'hFFFF_FFFF_FFFF_FFFF >> (63 - int'(m_slo[k][6:1]));
      sb  = {m_shi[k], m_slo[k][31:12], 12'h000};
      tb  = {m_thi[k], m_tlo[k][31:12], 12'h000};
      if (m_slo[k][0] && ((a & ~msk) == (sb & ~msk))) begin
        e.hit = 1'b1;
        e.addr = (tb & ~msk) | (a & msk);
        e.param = m_prm[k];
        e.idx = 3'(k);
      end
    end
    return e;
  endfunction

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    model_write(a, d);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [11:0] a, input string tag);
    logic [31:0] expv;
    expv = model_read(a);
    @(negedge clk);
    cfg_rd_en = 1'b1; cfg_rd_addr = a;
    @(negedge clk);
    cfg_rd_en = 1'b0;
    check(cfg_rd_data == expv, tag, 64'(cfg_rd_data), 64'(expv));
  endtask

  // driver: one lookup per call, lk_valid stays high until idle()
  task automatic look(input logic [63:0] a, input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    sb_q.push_back(model_lookup(a));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid = 1'b0;
    cfg_wr_en = 1'b0;
  endtask

  // R11: a write and a lookup in the same cycle
  task automatic look_and_write(input logic [63:0] a, input logic [11:0] wa,
                                input logic [31:0] wd, input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    sb_q.push_back(model_lookup(a));
    tag_q.push_back(tag);
    cfg_wr_en = 1'b1; cfg_wr_addr = wa; cfg_wr_data = wd;
    model_write(wa, wd);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R10 unexpected result", res_addr, 64'h0);
      end else begin
        exp_t  e;
        string t;
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (res_hit !== e.hit || res_addr !== e.addr || res_param !== e.param || res_index !== e.idx) begin
          n_fail++;
          $display("FAIL %s: actual hit=%b addr=%h param=%h idx=%0d expected hit=%b addr=%h param=%h idx=%0d",
                   t, res_hit, res_addr, res_param, res_index, e.hit, e.addr, e.param, e.idx);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) begin
      m_slo[k] = '0; m_shi[k] = '0; m_tlo[k] = '0; m_thi[k] = '0; m_prm[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0 && res_hit == 1'b0, "R1 result idle after reset", 64'({res_valid, res_hit}), 64'h0);
    reg_rd(12'h800, "R1 entry0 src-low zero");
    reg_rd(12'h8F0, "R1 entry7 param zero");
    look(64'h0000_0001_4000_0000, "R1 lookup misses on empty table");
    idle();

    // entry 0: 256 MB window, configuration type; reserved bits written as ones
    reg_wr(12'h800, 32'h4000_0F37);
    reg_wr(12'h804, 32'h0000_0001);
    reg_wr(12'h808, 32'h1234_5FFF);
    reg_wr(12'h80C, 32'h0000_00AB);
    reg_wr(12'h810, 32'h0000_0001);
    reg_rd(12'h800, "R3 src-low reserved bits read zero");
    reg_rd(12'h808, "R3 translated-low page bits read zero");
    reg_rd(12'h80C, "R2 translated-high readback");
    // entry 1: 1 MB window, direction bit set, memory type
    reg_wr(12'h820, 32'h8000_0027);
    reg_wr(12'h824, 32'h0);
    reg_wr(12'h828, 32'h0);
    reg_wr(12'h82C, 32'h0000_0020);
    reg_wr(12'h830, 32'h0040_0000);
    reg_rd(12'h830, "R2 entry1 param readback");
    // entry 2: 2 GB window overlapping entry 1
    reg_wr(12'h840, 32'h8000_003D);
    reg_wr(12'h84C, 32'h0000_0030);
    reg_wr(12'h850, 32'h0000_0000);
    // entry 3: matching base but disabled
    reg_wr(12'h860, 32'h0000_001E);
    reg_wr(12'h864, 32'h0000_0005);
    reg_wr(12'h86C, 32'h0000_0077);
    // entry 5: smallest window (2 bytes)
    reg_wr(12'h8A0, 32'h7000_0001);
    reg_wr(12'h8A8, 32'h9000_0000);
    reg_wr(12'h8B0, 32'h0040_0001);

    look(64'h0000_0001_4123_4567, "R5 entry0 translation");
    look(64'h0000_0001_4FFF_FFFF, "R4 entry0 top byte of window");
    look(64'h0000_0001_5000_0000, "R4 one past entry0 window");
    look(64'h0000_0000_8001_2345, "R7 overlap lowest entry wins");
    look(64'h0000_0000_800F_FFFF, "R7 entry1 last byte");
    look(64'h0000_0000_8010_0000, "R4 falls to entry2 past entry1");
    look(64'h0000_0000_9000_0000, "R9 entry2 memory param");
    look(64'h0000_0005_0000_0010, "R6 disabled entry ignored");
    look(64'h0000_0000_7000_0001, "R4 two-byte window hit");
    look(64'h0000_0000_7000_0002, "R4 two-byte window edge miss");
    look(64'hDEAD_BEEF_0000_1234, "R8 pass-through miss");
    idle();

    // R12: writes outside the register words change nothing
    reg_wr(12'h814, 32'hFFFF_FFFF);
    reg_wr(12'h000, 32'hFFFF_FFFF);
    reg_wr(12'h900, 32'hFFFF_FFFF);
    reg_wr(12'h802, 32'h0000_0000);
    reg_rd(12'h814, "R12 unused offset reads zero");
    reg_rd(12'h900, "R12 outside table reads zero");
    reg_rd(12'h800, "R12 entry0 src-low untouched");
    look(64'h0000_0001_4000_0040, "R12 entry0 still translates");
    idle();

    // R11: disable entry 5 in the same cycle as a lookup into it
    look_and_write(64'h0000_0000_7000_0001, 12'h8A0, 32'h7000_0000, "R11 same-cycle lookup sees old entry");
    look(64'h0000_0000_7000_0001, "R11 next lookup sees the write");
    idle();

    // largest window on entry 7 matches everything below priority
    reg_wr(12'h8E0, 32'h0000_007F);
    reg_wr(12'h8F0, 32'h0000_0001);
    look(64'hDEAD_BEEF_0000_1234, "R4 full-space window");
    look(64'h0000_0000_8001_0000, "R7 entry1 beats entry7");
    idle();
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R10 every lookup produced one result", 64'(sb_q.size()), 64'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule